// File: doc/BRIEF.md
# Interrupt Destination Delivery Router

This block takes one interrupt message per request cycle and decides which of a fixed group of local interrupt agents must receive it. A message carries a vector, an 8-bit destination, a 3-bit delivery mode, a destination-mode bit (physical or logical), a trigger bit and, for broadcast shorthands, an optional excluded agent index. Every agent presents its own 8-bit ID, its 8-bit logical destination mask, a priority value and a focus flag. From these the router forms the set of target agents in a single combinational pass. One clock later it presents a per-agent deliver strobe vector, a copy of the vector, mode and trigger bits, and an accepted flag that the sender uses to record a send-accept error.

Targeting covers physical unicast by ID match, physical broadcast through the all-ones destination, logical multicast by mask intersection, an explicit broadcast request with an optional excluded index, and lowest-priority arbitration. Arbitration first prefers an agent that already has focus on the vector, and otherwise picks the eligible agent with the smallest priority value. The control is a two-state machine. `ST_IDLE` holds while no request is present. The transition `idle_to_reply` fires on a request and loads the routing result. `ST_REPLY` presents that result for one cycle. From there `reply_to_reply` fires on a back-to-back request and `reply_to_idle` fires otherwise.

Top module: `irq_route_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_done`, `rsp_accepted` and every bit of `dlv_strobe` are 0.
- R2: A cycle with `req_valid` high is followed in the next cycle by `rsp_done` high for exactly that cycle. Without a request in the previous cycle `rsp_done`, `rsp_accepted` and `dlv_strobe` are 0. Back-to-back requests give back-to-back responses.
- R3: A lowest-priority message (`req_dmode` = 3'b001) with `req_logical` = 0 and `req_bcast` = 0 delivers to no agent and reports `rsp_accepted` = 0.
- R4: With `req_logical` = 0, `req_bcast` = 0, a mode other than lowest-priority and `req_dest` = 8'hFF, every agent is strobed and the message is accepted.
- R5: With `req_logical` = 0, `req_bcast` = 0, a mode other than lowest-priority and any other destination, only the lowest-index agent whose ID equals `req_dest` is strobed. If none matches, nothing is strobed and `rsp_accepted` = 0.
- R6: With `req_logical` = 1, a mode other than lowest-priority and `req_dest` = 0, no agent is strobed and the message is not accepted.
- R7: With `req_logical` = 1 and a mode other than lowest-priority, every agent whose logical mask ANDed with `req_dest` is nonzero is strobed. `rsp_accepted` is 1 exactly when at least one agent is strobed.
- R8: For a lowest-priority message that is not dropped by R3, if any agent raises its focus flag, the lowest-index such agent alone is strobed and the message is accepted. Focus is honoured whether or not that agent matches the destination.
- R9: Without focus, a logical lowest-priority message strobes the agent with the strictly smallest priority value among those whose mask intersects `req_dest`. Ties go to the lowest index. If no agent is eligible, nothing is strobed and `rsp_accepted` = 0.
- R10: With `req_bcast` = 1 and a mode other than lowest-priority, every agent is strobed except agent `req_excl_idx` when `req_excl_en` = 1. The message is always accepted.
- R11: With `req_bcast` = 1 and lowest-priority mode, every agent is eligible for arbitration under R8/R9 rules and `req_excl_en` has no effect.
- R12: A lowest-priority message strobes at most one agent. Any nonzero strobe vector comes with `rsp_accepted` = 1.
- R13: In the response cycle `dlv_vector`, `dlv_mode` and `dlv_trig` equal the `req_vector`, `req_dmode` and `req_trig` of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vector | input | 8 | Interrupt vector |
| req_dest | input | 8 | Destination ID or logical mask |
| req_dmode | input | 3 | Delivery mode, 3'b001 = lowest priority |
| req_logical | input | 1 | 1 = logical destination, 0 = physical |
| req_trig | input | 1 | Trigger mode (1 = level) |
| req_bcast | input | 1 | Broadcast to all agents |
| req_excl_en | input | 1 | Exclude one agent from a broadcast |
| req_excl_idx | input | 2 | Index of the excluded agent |
| agent_id | input | 32 | Per-agent IDs, agent k at bits [8k+7:8k] |
| agent_ldest | input | 32 | Per-agent logical masks, agent k at bits [8k+7:8k] |
| agent_prio | input | 32 | Per-agent priority values, agent k at bits [8k+7:8k] |
| agent_focus | input | 4 | Per-agent focus flag on the vector |
| rsp_done | output | 1 | Response cycle |
| rsp_accepted | output | 1 | Message reached at least one agent |
| dlv_strobe | output | 4 | Per-agent deliver strobe |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered mode |
| dlv_trig | output | 1 | Delivered trigger mode |

## Verification
The bench builds the router with its defaults: four agents, 8-bit IDs and 8-bit priorities. With four agents, duplicate IDs, overlapping logical masks, priority ties and an excluded index at either end of the group can all be set up by hand. The same width lets randomized IDs drawn from a small range collide often. This makes first-match selection, tie breaking and focus overriding the destination frequent events rather than rare ones.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [2:0] DMODE_LOWEST = 3'b001;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } route_state_e;

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 8
) (
    input  logic [ID_W-1:0]          dest,
    input  logic [N_AGENTS*ID_W-1:0] ids,
    input  logic [N_AGENTS*ID_W-1:0] masks,
    output logic [N_AGENTS-1:0]      phys_first,
    output logic                     phys_all,
    output logic [N_AGENTS-1:0]      logic_hit
);

    logic [N_AGENTS-1:0] id_eq;

    // Per-agent comparators
    for (genvar k = 0; k < N_AGENTS; k++) begin : g_cmp
        assign id_eq[k]     = (ids[k*ID_W +: ID_W] == dest);
        assign logic_hit[k] = |(masks[k*ID_W +: ID_W] & dest);
    end

    assign phys_all = (dest == {ID_W{1'b1}});

    // Keep only the lowest-index ID match
    always_comb begin
        logic seen;
        seen       = 1'b0;
        phys_first = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (id_eq[k] && !seen) begin
                phys_first[k] = 1'b1;
                seen          = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_lowpri_arb.sv
module irq_lowpri_arb #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8
) (
    input  logic [N_AGENTS-1:0]        eligible,
    input  logic [N_AGENTS-1:0]        focus,
    input  logic [N_AGENTS*PRIO_W-1:0] prio,
    output logic [N_AGENTS-1:0]        pick,
    output logic                       found
);

    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    logic [N_AGENTS-1:0] focus_pick;
    logic                focus_any;
    logic [N_AGENTS-1:0] min_pick;
    logic                min_any;

    // Focus winner: lowest index with the flag set
    always_comb begin
        focus_pick = '0;
        focus_any  = 1'b0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (focus[k] && !focus_any) begin
                focus_pick[k] = 1'b1;
                focus_any     = 1'b1;
            end
        end
    end

    // Minimum search, strict compare keeps the earlier index on ties
    always_comb begin
        logic [PRIO_W-1:0] best;
        logic [IDX_W-1:0]  best_idx;
        best     = '1;
        best_idx = '0;
        min_any  = 1'b0;
        min_pick = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (eligible[k] && (!min_any || prio[k*PRIO_W +: PRIO_W] < best)) begin
                best     = prio[k*PRIO_W +: PRIO_W];
                best_idx = IDX_W'(k);
                min_any  = 1'b1;
            end
        end
        if (min_any) min_pick[best_idx] = 1'b1;
    end

    assign pick  = focus_any ? focus_pick : min_pick;
    assign found = focus_any | min_any;

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 8,
    parameter int PRIO_W   = 8,
    parameter int VEC_W    = 8,
    localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VEC_W-1:0]           req_vector,
    input  logic [ID_W-1:0]            req_dest,
    input  logic [2:0]                 req_dmode,
    input  logic                       req_logical,
    input  logic                       req_trig,
    input  logic                       req_bcast,
    input  logic                       req_excl_en,
    input  logic [IDX_W-1:0]           req_excl_idx,
    input  logic [N_AGENTS*ID_W-1:0]   agent_id,
    input  logic [N_AGENTS*ID_W-1:0]   agent_ldest,
    input  logic [N_AGENTS*PRIO_W-1:0] agent_prio,
    input  logic [N_AGENTS-1:0]        agent_focus,
    output logic                       rsp_done,
    output logic                       rsp_accepted,
    output logic [N_AGENTS-1:0]        dlv_strobe,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [2:0]                 dlv_mode,
    output logic                       dlv_trig
);

    import irq_route_pkg::*;

    route_state_e state_q, state_d;

    logic [N_AGENTS-1:0] phys_first, logic_hit, arb_elig, arb_pick;
    logic                phys_all, arb_found, is_lowest;
    logic [N_AGENTS-1:0] route_set;
    logic                route_acc;

    irq_dest_match #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_match (
        .dest      (req_dest),
        .ids       (agent_id),
        .masks     (agent_ldest),
        .phys_first(phys_first),
        .phys_all  (phys_all),
        .logic_hit (logic_hit)
    );

    irq_lowpri_arb #(.N_AGENTS(N_AGENTS), .PRIO_W(PRIO_W)) u_arb (
        .eligible(arb_elig),
        .focus   (agent_focus),
        .prio    (agent_prio),
        .pick    (arb_pick),
        .found   (arb_found)
    );

    assign is_lowest = (req_dmode == DMODE_LOWEST);

    // Targeting decision
    always_comb begin
        route_set = '0;
        route_acc = 1'b0;
        arb_elig  = '0;
        if (req_bcast) begin
            if (is_lowest) begin
                arb_elig  = '1;
                route_set = arb_pick;
                route_acc = arb_found;
            end else begin
                route_set = '1;
                if (req_excl_en) route_set[req_excl_idx] = 1'b0;
                route_acc = 1'b1;
            end
        end else if (is_lowest) begin
            if (req_logical) begin
                arb_elig  = logic_hit;
                route_set = arb_pick;
                route_acc = arb_found;
            end
        end else if (!req_logical) begin
            if (phys_all) begin
                route_set = '1;
                route_acc = 1'b1;
            end else begin
                route_set = phys_first;
                route_acc = |phys_first;
            end
        end else begin
            route_set = logic_hit;
            route_acc = |logic_hit;
        end
    end

    // Next state: idle_to_reply, reply_to_reply, reply_to_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_strobe   <= '0;
            rsp_accepted <= 1'b0;
            dlv_vector   <= '0;
            dlv_mode     <= '0;
            dlv_trig     <= 1'b0;
        end else if (req_valid) begin
            dlv_strobe   <= route_set;
            rsp_accepted <= route_acc;
            dlv_vector   <= req_vector;
            dlv_mode     <= req_dmode;
            dlv_trig     <= req_trig;
        end else begin
            dlv_strobe   <= '0;
            rsp_accepted <= 1'b0;
        end
    end

    assign rsp_done = (state_q == ST_REPLY);

    // Assertions
    p_reply_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    p_quiet_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_done && !rsp_accepted && dlv_strobe == '0));

    p_phys_lowest_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_lowest && !req_logical && !req_bcast)
        |=> (!rsp_accepted && dlv_strobe == '0));

    p_lowest_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_lowest) |=> $onehot0(dlv_strobe));

    p_strobe_means_acc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_strobe != '0) |-> rsp_accepted);

    p_vector_copy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (dlv_vector == $past(req_vector) && dlv_trig == $past(req_trig)));

    p_bcast_fixed_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bcast && !is_lowest) |=> rsp_accepted);

endmodule

// File: tb/irq_route_top_tb_top.sv
module irq_route_top_tb_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [7:0]  req_dest = '0;
    logic [2:0]  req_dmode = '0;
    logic        req_logical = 1'b0;
    logic        req_trig = 1'b0;
    logic        req_bcast = 1'b0;
    logic        req_excl_en = 1'b0;
    logic [1:0]  req_excl_idx = '0;
    logic [31:0] agent_id = '0;
    logic [31:0] agent_ldest = '0;
    logic [31:0] agent_prio = '0;
    logic [3:0]  agent_focus = '0;
    logic        rsp_done, rsp_accepted, dlv_trig;
    logic [3:0]  dlv_strobe;
    logic [7:0]  dlv_vector;
    logic [2:0]  dlv_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0] set;
        logic       acc;
        logic [7:0] vec;
        logic [2:0] mode;
        logic       trig;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    irq_route_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_dest(req_dest), .req_dmode(req_dmode), .req_logical(req_logical),
        .req_trig(req_trig), .req_bcast(req_bcast), .req_excl_en(req_excl_en),
        .req_excl_idx(req_excl_idx), .agent_id(agent_id), .agent_ldest(agent_ldest),
        .agent_prio(agent_prio), .agent_focus(agent_focus), .rsp_done(rsp_done),
        .rsp_accepted(rsp_accepted), .dlv_strobe(dlv_strobe), .dlv_vector(dlv_vector),
        .dlv_mode(dlv_mode), .dlv_trig(dlv_trig)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(output exp_t e);
        int best;
        int fidx;
        e.set = '0; e.acc = 1'b0; e.tag = "";
        e.vec = req_vector; e.mode = req_dmode; e.trig = req_trig;
        if (req_dmode == 3'b001 && (req_bcast || req_logical)) begin
            fidx = -1;
            for (int k = 0; k < N; k++) if (agent_focus[k] && fidx < 0) fidx = k;
            if (fidx >= 0) begin
                e.set[fidx] = 1'b1; e.acc = 1'b1; e.tag = "R8";
            end else begin
                best = -1;
                for (int k = 0; k < N; k++) begin
                    if (req_bcast || (agent_ldest[k*8 +: 8] & req_dest) != 0) begin
                        if (best < 0 || agent_prio[k*8 +: 8] < agent_prio[best*8 +: 8]) best = k;
                    end
                end
                if (best >= 0) begin e.set[best] = 1'b1; e.acc = 1'b1; end
                e.tag = req_bcast ? "R11" : "R9";
            end
        end else if (req_bcast) begin
            e.set = 4'hF;
            if (req_excl_en) e.set[req_excl_idx] = 1'b0;
            e.acc = 1'b1; e.tag = "R10";
        end else if (req_dmode == 3'b001) begin
            e.tag = "R3";
        end else if (!req_logical) begin
            if (req_dest == 8'hFF) begin
                e.set = 4'hF; e.acc = 1'b1; e.tag = "R4";
            end else begin
                for (int k = 0; k < N; k++)
                    if (agent_id[k*8 +: 8] == req_dest && e.set == 0) e.set[k] = 1'b1;
                e.acc = (e.set != 0); e.tag = "R5";
            end
        end else begin
            for (int k = 0; k < N; k++)
                if ((agent_ldest[k*8 +: 8] & req_dest) != 0) e.set[k] = 1'b1;
            e.acc = (e.set != 0);
            e.tag = (req_dest == 0) ? "R6" : "R7";
        end
    endtask

    // Driver: called right after a negedge, holds request for one cycle
    task automatic send(input logic [7:0] vec, input logic [7:0] dest, input logic [2:0] mode,
                        input logic lg, input logic bc, input logic xen, input logic [1:0] xi);
        exp_t e;
        req_vector = vec; req_dest = dest; req_dmode = mode; req_logical = lg;
        req_trig = vec[0]; req_bcast = bc; req_excl_en = xen; req_excl_idx = xi;
        req_valid = 1'b1;
        #1;
        model(e);
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_done) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", 32'(rsp_done), 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(dlv_strobe == e.set, e.tag, 32'(dlv_strobe), 32'(e.set));
                    chk(rsp_accepted == e.acc, e.tag, 32'(rsp_accepted), 32'(e.acc));
                    chk(dlv_vector == e.vec && dlv_mode == e.mode && dlv_trig == e.trig, "R13",
                        {dlv_trig, dlv_mode, dlv_vector}, {e.trig, e.mode, e.vec});
                    chk(!(e.mode == 3'b001 && $countones(dlv_strobe) > 1), "R12",
                        32'(dlv_strobe), 32'(e.set));
                end
            end else begin
                chk(sb.size() == 0 && dlv_strobe == 0 && !rsp_accepted, "R2 missing or noisy response",
                    {dlv_strobe, 3'b0, rsp_accepted}, 32'h0);
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!rsp_done && !rsp_accepted && dlv_strobe == 0, "R1 during reset",
            {dlv_strobe, 2'b0, rsp_done, rsp_accepted}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_done && !rsp_accepted && dlv_strobe == 0, "R1 after reset",
            {dlv_strobe, 2'b0, rsp_done, rsp_accepted}, 32'h0);

        agent_id    = {8'h10, 8'h03, 8'h07, 8'h03};
        agent_ldest = {8'h0C, 8'h04, 8'h02, 8'h01};
        agent_prio  = {8'd9, 8'd3, 8'd3, 8'd5};
        agent_focus = 4'b0000;

        send(8'h40, 8'h03, 3'b000, 0, 0, 0, 0); // R5 first match -> agent0
        send(8'h41, 8'h22, 3'b000, 0, 0, 0, 0); // R5 no match
        send(8'h42, 8'hFF, 3'b000, 0, 0, 0, 0); // R4
        send(8'h43, 8'h03, 3'b001, 0, 0, 0, 0); // R3 drop
        send(8'h44, 8'h04, 3'b000, 1, 0, 0, 0); // R7 agents 2,3
        send(8'h45, 8'h00, 3'b000, 1, 0, 0, 0); // R6
        send(8'h46, 8'h10, 3'b000, 1, 0, 0, 0); // R7 none
        send(8'h47, 8'h0F, 3'b001, 1, 0, 0, 0); // R9 tie -> agent1
        send(8'h48, 8'h00, 3'b001, 1, 0, 0, 0); // R9 none eligible
        agent_focus = 4'b1100;
        send(8'h49, 8'h01, 3'b001, 1, 0, 0, 0); // R8 focus -> agent2
        agent_focus = 4'b0000;
        send(8'h4A, 8'h00, 3'b000, 0, 1, 1, 2); // R10 exclude 2
        send(8'h4B, 8'h00, 3'b000, 0, 1, 0, 2); // R10 no exclusion
        send(8'h4C, 8'h00, 3'b000, 0, 1, 1, 3); // R10 exclude top index
        agent_prio = {8'd9, 8'd3, 8'd1, 8'd5};
        send(8'h4D, 8'h00, 3'b001, 0, 1, 1, 1); // R11 exclusion ignored -> agent1
        @(negedge clk);

        for (int i = 0; i < 400; i++) begin
            agent_id    = {4'h0, 4'($urandom_range(0, 3)), 4'h0, 4'($urandom_range(0, 3)),
                           4'h0, 4'($urandom_range(0, 3)), 4'h0, 4'($urandom_range(0, 3))};
            agent_ldest = $urandom;
            agent_prio  = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                           8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
            agent_focus = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            send(8'($urandom), ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 5)),
                 ($urandom_range(0, 1) != 0) ? 3'b001 : 3'($urandom),
                 1'($urandom), ($urandom_range(0, 4) == 0), 1'($urandom), 2'($urandom));
            if (i % 7 == 0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 outstanding responses", 32'(sb.size()), 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule